// File: doc/BRIEF.md
# Bit-Serial Flash Word Port

This block sits between a memory-mapped master and a small on-chip flash array model. The master moves data one bit per cycle. A program command carries the word address and a bit count. After a short address phase, the block takes 32 serial bits, most significant bit first, and commits them as one 32-bit word.

A read command returns stored words one bit per cycle, most significant bit first, marked by `readdatavalid`. The read can span up to 128 consecutive words. Each program and each read ends by updating a pass/fail flag. A two-bit busy code shows which operation is running.

The array is reset to the erased state, which is all ones. Programming can only clear bits, so the stored word becomes the old word ANDed with the new data. A per-sector lock input blocks both programming and reading of the words in that sector. A sector is 16 consecutive words: sector = address / 16.

Top module: `sflash_port`

## Requirements
- R1: After reset, `busy` is 00 and `waitrequest`, `readdatavalid`, `write_ok` and `read_ok` are 0. Every array word reads back as 32'hFFFFFFFF.
- R2: A program whose `burstcount` is not exactly 32 is rejected at the acceptance edge. No address phase and no data beats follow. `write_ok` is 0 and `busy` is 00 on the next cycle.
- R3: An accepted command holds `waitrequest` high for SETUP (2) cycles of address phase. During that phase `busy` reads 10 for a program and 11 for a read. Once serial data starts, the busy code stays the same.
- R4: Program data is sampled on cycles where `write` is high and `waitrequest` is low. The first accepted bit is bit 31 and the 32nd is bit 0. Cycles with `write` low are not counted.
- R5: A legal program commits on its 32nd accepted bit. The word becomes old AND new, `write_ok` is 1 and `busy` is 00 on the next cycle.
- R6: A program to an address at or above 64, or to a sector whose `sector_lock` bit is 1, still takes all 32 bits. It leaves every word unchanged and clears `write_ok`.
- R7: A read with a legal `burstcount` delivers exactly `burstcount` bits on consecutive cycles with `readdatavalid` high. Each word is sent bit 31 first. `waitrequest` stays high for the whole read. A burst of 128 words (4096 bits) is legal.
- R8: In a multi-word read, the word address advances by one after every 32 bits.
- R9: A word at an illegal address, or in a locked sector, is delivered as all ones and makes `read_ok` 0 at the end of the read. A read with no such word ends with `read_ok` 1.
- R10: A read whose `burstcount` is zero, not a multiple of 32, or above 4096 is rejected. It produces no valid bits, `read_ok` is 0 and `busy` is 00 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; erases the array |
| address | input | AW (8) | Word address, sampled when a command is accepted |
| read | input | 1 | Read command, accepted while idle |
| write | input | 1 | Program command while idle; bit strobe during data phase |
| writedata | input | 1 | Serial program data bit |
| burstcount | input | 13 | Burst length in bits |
| sector_lock | input | 4 | One lock bit per 16-word sector |
| readdata | output | 1 | Serial read data bit |
| readdatavalid | output | 1 | High on cycles carrying a read bit |
| waitrequest | output | 1 | High during address phases and read bursts |
| busy | output | 2 | 00 idle, 10 programming, 11 reading |
| write_ok | output | 1 | Result of the last program |
| read_ok | output | 1 | Result of the last read |

## Verification
The embedded properties watch the following on every cycle:
- rejection of bad bit counts for both commands, with the flag and busy code that follow;
- `waitrequest` rising as any operation starts;
- `readdatavalid` only appearing inside a busy read;
- all-ones output for words flagged illegal;
- the pass or fail flag after each commit.

Some outcomes depend on the contents of the array over several operations, so only the bench scenarios can show them:
- bit order and the AND-only commit;
- locked and out-of-range words staying untouched;
- address advance across word boundaries;
- the exact number of valid bits in a full 128-word burst.

// File: rtl/sflash_port.sv
module sflash_port #(
  parameter int AW           = 8,
  parameter int NUM_WORDS    = 64,
  parameter int SECTOR_WORDS = 16,
  parameter int MAX_WORDS    = 128,
  parameter int SETUP        = 2,
  localparam int WW    = 32,
  localparam int BCW   = $clog2(MAX_WORDS * WW) + 1,
  localparam int NSEC  = NUM_WORDS / SECTOR_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   address,
  input  logic            read,
  input  logic            write,
  input  logic            writedata,
  input  logic [BCW-1:0]  burstcount,
  input  logic [NSEC-1:0] sector_lock,
  output logic            readdata,
  output logic            readdatavalid,
  output logic            waitrequest,
  output logic [1:0]      busy,
  output logic            write_ok,
  output logic            read_ok
);

  localparam int SEC_SH = $clog2(SECTOR_WORDS);
  localparam int SEC_W  = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam int LW     = $clog2(WW);
  localparam int SCW    = (SETUP > 1) ? $clog2(SETUP + 1) : 1;
  localparam logic [AW:0]    LIMIT   = (AW+1)'(NUM_WORDS);
  localparam logic [BCW-1:0] BC_WORD = BCW'(WW);
  localparam logic [BCW-1:0] BC_MAX  = BCW'(MAX_WORDS * WW);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WDAT, S_RSET, S_RDAT} st_t;

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic [WW-1:0]  sh;
  logic [LW-1:0]  bit_cnt;
  logic [BCW-1:0] rem;
  logic [SCW-1:0] set_cnt;
  logic           wfail, rerr, word_bad;
  logic [WW-1:0]  mem [NUM_WORDS];

  function automatic logic addr_bad(input logic [AW-1:0] a, input logic [NSEC-1:0] lk);
    logic [SEC_W-1:0] s;
    s = SEC_W'(a >> SEC_SH);
    return ({1'b0, a} >= LIMIT) || lk[s];
  endfunction

  logic [AW-1:0] fetch_addr;
  logic          fetch_bad;
  logic [WW-1:0] fetch_word;
  logic          rd_bc_ok;

  assign fetch_addr = (st == S_RSET) ? addr_q : addr_q + 1'b1;
  assign fetch_bad  = addr_bad(fetch_addr, sector_lock);
  assign fetch_word = fetch_bad ? '1 : mem[fetch_addr[IDX_W-1:0]];
  assign rd_bc_ok   = (burstcount[LW-1:0] == '0) && (burstcount != '0) && (burstcount <= BC_MAX);

  assign readdatavalid = (st == S_RDAT);
  assign readdata      = (st == S_RDAT) & sh[WW-1];
  assign waitrequest   = (st == S_WSET) || (st == S_RSET) || (st == S_RDAT);
  assign busy          = (st == S_WSET || st == S_WDAT) ? 2'b10 :
                         (st == S_RSET || st == S_RDAT) ? 2'b11 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      sh       <= '0;
      bit_cnt  <= '0;
      rem      <= '0;
      set_cnt  <= '0;
      wfail    <= 1'b0;
      rerr     <= 1'b0;
      word_bad <= 1'b0;
      write_ok <= 1'b0;
      read_ok  <= 1'b0;
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
    end else begin
      case (st)
        S_IDLE: begin
          if (write) begin
            addr_q <= address;
            if (burstcount == BC_WORD) begin
              st      <= S_WSET;
              set_cnt <= SCW'(SETUP - 1);
              wfail   <= addr_bad(address, sector_lock);
              bit_cnt <= '0;
            end else begin
              write_ok <= 1'b0;
            end
          end else if (read) begin
            addr_q <= address;
            if (rd_bc_ok) begin
              st      <= S_RSET;
              set_cnt <= SCW'(SETUP - 1);
              rem     <= burstcount;
              rerr    <= 1'b0;
            end else begin
              read_ok <= 1'b0;
            end
          end
        end
        S_WSET: begin
          if (set_cnt == '0) st <= S_WDAT;
          else set_cnt <= set_cnt - 1'b1;
        end
        S_WDAT: begin
          if (write) begin
            sh      <= {sh[WW-2:0], writedata};
            bit_cnt <= bit_cnt + 1'b1;
            if (&bit_cnt) begin
              st       <= S_IDLE;
              write_ok <= !wfail;
              if (!wfail)
                mem[addr_q[IDX_W-1:0]] <= mem[addr_q[IDX_W-1:0]] & {sh[WW-2:0], writedata};
            end
          end
        end
        S_RSET: begin
          if (set_cnt == '0) begin
            st       <= S_RDAT;
            sh       <= fetch_word;
            word_bad <= fetch_bad;
            rerr     <= fetch_bad;
            bit_cnt  <= '0;
          end else begin
            set_cnt <= set_cnt - 1'b1;
          end
        end
        S_RDAT: begin
          rem <= rem - 1'b1;
          if (rem == BCW'(1)) begin
            st      <= S_IDLE;
            read_ok <= !rerr;
          end else if (&bit_cnt) begin
            addr_q   <= addr_q + 1'b1;
            sh       <= fetch_word;
            word_bad <= fetch_bad;
            rerr     <= rerr | fetch_bad;
            bit_cnt  <= '0;
          end else begin
            sh      <= {sh[WW-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reject_prog_bc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && write && burstcount != BC_WORD) |=> (busy == 2'b00 && !write_ok));

  assert_setup_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != 2'b00 && $past(busy) == 2'b00) |-> waitrequest);

  assert_commit_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && write && &bit_cnt && !wfail) |=> (write_ok && busy == 2'b00));

  assert_commit_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && write && &bit_cnt && wfail) |=> (!write_ok && busy == 2'b00));

  assert_valid_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    readdatavalid |-> (waitrequest && busy == 2'b11));

  assert_ones_on_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readdatavalid && word_bad) |-> readdata);

  assert_reject_read_bc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !write && read && !rd_bc_ok) |=> (busy == 2'b00 && !read_ok && !readdatavalid));

endmodule

// File: tb/sflash_port_tb.sv
`timescale 1ns/1ps
module sflash_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] address = 0;
  logic read = 0, write = 0, writedata = 0;
  logic [12:0] burstcount = 0;
  logic [3:0] sector_lock = 0;
  logic readdata, readdatavalid, waitrequest, write_ok, read_ok;
  logic [1:0] busy;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sflash_port dut_i (.clk(clk), .rst_n(rst_n), .address(address), .read(read), .write(write),
    .writedata(writedata), .burstcount(burstcount), .sector_lock(sector_lock), .readdata(readdata),
    .readdatavalid(readdatavalid), .waitrequest(waitrequest), .busy(busy),
    .write_ok(write_ok), .read_ok(read_ok));

  // {addr, data, lock, exp write_ok, exp readback, exp read_ok}
  localparam logic [77:0] TBL [8] = '{
    {8'h00, 32'hA5A50F0F, 4'h0, 1'b1, 32'hA5A50F0F, 1'b1},
    {8'h15, 32'h12345678, 4'h0, 1'b1, 32'h12345678, 1'b1},
    {8'h22, 32'h00000000, 4'h4, 1'b0, 32'hFFFFFFFF, 1'b0},
    {8'h3F, 32'h80000001, 4'h0, 1'b1, 32'h80000001, 1'b1},
    {8'h40, 32'h00000000, 4'h0, 1'b0, 32'hFFFFFFFF, 1'b0},
    {8'h22, 32'hDEADBEEF, 4'h0, 1'b1, 32'hDEADBEEF, 1'b1},
    {8'h00, 32'hFFFF00FF, 4'h0, 1'b1, 32'hA5A5000F, 1'b1},
    {8'h31, 32'h00000000, 4'h8, 1'b0, 32'hFFFFFFFF, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [7:0] a, input logic [12:0] bc, input logic [31:0] d,
                      input int gap_at, output int wset, output logic [1:0] bsy, output logic acc);
    @(negedge clk); address = a; burstcount = bc; write = 1;
    @(negedge clk); write = 0;
    wset = 0; bsy = busy; acc = (busy != 2'b00);
    if (acc) begin
      while (waitrequest && wset < 20) begin wset++; @(negedge clk); end
      for (int i = 31; i >= 0; i--) begin
        if (i == gap_at) begin write = 0; @(negedge clk); end
        write = 1; writedata = d[i];
        @(negedge clk);
      end
      write = 0;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [12:0] bc, output int nval, output int nwait,
                    output logic [127:0] rbits, output logic gap, output logic [1:0] bsy);
    bit seen;
    @(negedge clk); address = a; burstcount = bc; read = 1;
    @(negedge clk); read = 0;
    nval = 0; nwait = 0; rbits = '0; gap = 0; bsy = busy; seen = 0;
    for (int k = 0; k < 5000; k++) begin
      if (busy == 2'b00) break;
      if (readdatavalid) begin
        if (!waitrequest) gap = 1;
        nval++; rbits = {rbits[126:0], readdata}; seen = 1;
      end else begin
        if (seen) gap = 1;
        if (waitrequest) nwait++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nv, nw, ws; logic [127:0] rb; logic g, acc; logic [1:0] bs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 2'b00 && !waitrequest && !readdatavalid && !write_ok && !read_ok, "R1",
        {busy, waitrequest, readdatavalid, write_ok, read_ok}, 0);
    rd(8'h05, 32, nv, nw, rb, g, bs);
    chk(rb[31:0] == 32'hFFFFFFFF && read_ok, "R1 erased", rb[31:0], 32'hFFFFFFFF);

    // table: program then read back
    for (int e = 0; e < 8; e++) begin
      sector_lock = TBL[e][37:34];
      prog(TBL[e][77:70], 32, TBL[e][69:38], -1, ws, bs, acc);
      chk(write_ok == TBL[e][33], TBL[e][33] ? "R5 write_ok" : "R6 write_ok", write_ok, TBL[e][33]);
      rd(TBL[e][77:70], 32, nv, nw, rb, g, bs);
      chk(rb[31:0] == TBL[e][32:1], TBL[e][0] ? "R5 readback" : "R9 ones", rb[31:0], TBL[e][32:1]);
      chk(read_ok == TBL[e][0] && nv == 32, "R9 read_ok/R7 count", {read_ok, 32'(nv)}, {TBL[e][0], 32'd32});
    end
    sector_lock = 0;

    // R6: blocked program left word untouched
    rd(8'h31, 32, nv, nw, rb, g, bs);
    chk(rb[31:0] == 32'hFFFFFFFF && read_ok, "R6 untouched", rb[31:0], 32'hFFFFFFFF);

    // R2: wrong burstcount rejected
    prog(8'h05, 32, 32'h0000FFFF, -1, ws, bs, acc);
    chk(write_ok, "R5 setup", write_ok, 1);
    prog(8'h05, 64, 32'h00000000, -1, ws, bs, acc);
    chk(!acc && !write_ok && busy == 2'b00, "R2 reject 64", {acc, write_ok, busy}, 0);
    prog(8'h05, 33, 32'h00000000, -1, ws, bs, acc);
    chk(!acc && !write_ok, "R2 reject 33", {acc, write_ok}, 0);
    rd(8'h05, 32, nv, nw, rb, g, bs);
    chk(rb[31:0] == 32'h0000FFFF, "R2 unchanged", rb[31:0], 32'h0000FFFF);

    // R4 stalled serial data, R3 address phase for program
    prog(8'h06, 32, 32'hC3C35A5A, 16, ws, bs, acc);
    chk(ws == 2 && bs == 2'b10, "R3 program phase", {32'(ws), 30'd0, bs}, {32'd2, 30'd0, 2'b10});
    rd(8'h06, 32, nv, nw, rb, g, bs);
    chk(rb[31:0] == 32'hC3C35A5A, "R4 stall order", rb[31:0], 32'hC3C35A5A);
    chk(nw == 2 && bs == 2'b11, "R3 read phase", {32'(nw), 30'd0, bs}, {32'd2, 30'd0, 2'b11});

    // R8 multi-word read
    rd(8'h14, 64, nv, nw, rb, g, bs);
    chk(rb[63:0] == {32'hFFFFFFFF, 32'h12345678} && nv == 64 && !g && read_ok, "R8 two words",
        rb[63:0], {32'hFFFFFFFF, 32'h12345678});

    // R9 burst running past the array end
    rd(8'h3F, 64, nv, nw, rb, g, bs);
    chk(rb[63:0] == {32'h80000001, 32'hFFFFFFFF} && !read_ok, "R9 past end",
        rb[63:0], {32'h80000001, 32'hFFFFFFFF});

    // R10 illegal read burstcount
    rd(8'h00, 32, nv, nw, rb, g, bs);
    chk(read_ok, "R9 good read", read_ok, 1);
    rd(8'h00, 40, nv, nw, rb, g, bs);
    chk(nv == 0 && !read_ok && busy == 2'b00, "R10 bc 40", {32'(nv), 31'd0, read_ok}, 0);
    rd(8'h00, 32, nv, nw, rb, g, bs);
    rd(8'h00, 0, nv, nw, rb, g, bs);
    chk(nv == 0 && !read_ok, "R10 bc 0", {32'(nv), 31'd0, read_ok}, 0);
    rd(8'h00, 4128, nv, nw, rb, g, bs);
    chk(nv == 0, "R10 bc 4128", nv, 0);

    // R7 maximum burst
    rd(8'h00, 4096, nv, nw, rb, g, bs);
    chk(nv == 4096 && !g, "R7 max burst", {32'(nv), 31'd0, g}, {32'd4096, 32'd0});
    chk(!read_ok && rb[31:0] == 32'hFFFFFFFF, "R9 tail ones", rb[31:0], 32'hFFFFFFFF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule